// File: doc/BRIEF.md
# Multiplexed Byte-Wide Peripheral Bus Master

This block lets internal logic reach a slow framer-style microprocessor port through one shared 8-bit lane set. That lane set carries address and data at different times. It accepts one read or write request at a time and sends the address over the lanes in two byte phases. Each phase ends with a latch-clock pulse so that external buffers can hold the byte. It then lowers chip select together with the read or write strobe. A read byte comes back on a one-cycle response pulse.

The strobe phase ends in one of two ways. In fixed mode it lasts a set number of cycles, so the whole access, address phases included, takes ten bus cycles. In acknowledge mode it ends when the peripheral pulls its active-low ready line low. If that line never falls, a programmable timeout ends the access and marks an error. Every access ends with three turnaround cycles, and no new request is taken until they are over.

Top module: `mux_bus_master`

## Requirements
- R1: In reset and directly after it, req_ready is 1, bus_cs_n, bus_rd_n and bus_wr_n are 1, bus_latch is 0, bus_ad_oe is 0 and rsp_valid is 0.
- R2: A request is accepted only at a rising edge where req_valid and req_ready are both 1. req_ready is 1 only while the controller is idle, and req_valid seen while req_ready is 0 has no effect.
- R3: The four cycles after acceptance are address cycles, with bus_ad_oe=1, bus_dir=1 and all strobes high. Cycles 1 and 2 drive the address bits above bit 7, right-aligned with zero fill (for the default 11-bit address: {5'b0,A[10:8]}). Cycles 3 and 4 drive A[7:0]. bus_latch is 1 only in cycles 2 and 4.
- R4: In the strobe phase, bus_cs_n=0 and exactly one of bus_rd_n (read) or bus_wr_n (write, req_write=1) is 0. A write drives the write byte with bus_ad_oe=1 and bus_dir=1. In fixed mode (ack_mode=0) the strobe phase lasts ACCESS_CYC-4 = 6 cycles, so the access spans 10 cycles, and bus_ack_n is ignored.
- R5: During a read strobe, bus_ad_oe=0 and bus_dir=0. The read byte is bus_ad_in as sampled at the rising edge that ends the last strobe cycle.
- R6: rsp_valid is 1 for exactly one cycle: the cycle right after the last strobe cycle. rsp_rdata is then the sampled byte for reads and 0 for writes. rsp_err is 0 in fixed mode and is 1 only together with rsp_valid.
- R7: In acknowledge mode (ack_mode=1, sampled with the request), the strobe phase ends with the first strobe cycle whose closing rising edge sees bus_ack_n=0, and rsp_err is 0.
- R8: In acknowledge mode, if no acknowledge arrives within max(timeout_lim,1) strobe cycles, the strobe phase ends after that many cycles with rsp_err=1. An acknowledge in the final allowed cycle counts as success.
- R9: After the strobe phase come TURN_CYC = 3 turnaround cycles, with strobes high, bus_latch 0, bus_ad_oe 0 and req_ready 0. req_ready returns to 1 in the cycle after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Peripheral address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request can be taken |
| ack_mode | input | 1 | 1 = strobe ends on acknowledge or timeout |
| timeout_lim | input | TO_W | Strobe cycle limit in acknowledge mode |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte |
| rsp_err | output | 1 | Acknowledge timeout flag |
| bus_ad_out | output | 8 | Shared lanes, outbound value |
| bus_ad_oe | output | 1 | Lane output enable |
| bus_ad_in | input | 8 | Shared lanes, inbound value |
| bus_dir | output | 1 | External buffer direction, 1 = toward peripheral |
| bus_latch | output | 1 | Address latch clock |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ack_n | input | 1 | Peripheral acknowledge, active low |

## Verification
The hardest case to reach is the edge of the acknowledge window. The acknowledge has to fall in exactly the last strobe cycle the timeout allows, where it must count as success, or one cycle later, where the access must end in error with the acknowledge ignored. The bench plays the peripheral itself. It counts strobe cycles at the ports and lowers bus_ack_n at a chosen strobe index, which places the acknowledge at, just before or past the limit, including a limit of zero. It also holds req_valid high with junk fields through a whole access, to show that nothing is taken before idle.

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
  parameter int ADDR_W     = 11,
  parameter int ACCESS_CYC = 10,
  parameter int TURN_CYC   = 3,
  parameter int TO_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  input  logic              ack_mode,
  input  logic [TO_W-1:0]   timeout_lim,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              rsp_err,
  output logic [7:0]        bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [7:0]        bus_ad_in,
  output logic              bus_dir,
  output logic              bus_latch,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  input  logic              bus_ack_n
);

  localparam int STRB_CYC = ACCESS_CYC - 4;
  localparam int CNT_W    = TO_W + 4;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STRB, S_TURN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q, mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wd_q;
  logic [TO_W-1:0]   lim_q;
  logic [15:0]       a_ext;
  logic              in_addr, in_strb, ack_seen, to_hit, strb_done;

  assign a_ext     = 16'(addr_q);
  assign in_addr   = (st == S_ADDR);
  assign in_strb   = (st == S_STRB);
  assign ack_seen  = ~bus_ack_n;
  assign to_hit    = (cnt + CNT_W'(1)) >= CNT_W'(lim_q);
  assign strb_done = mode_q ? (ack_seen | to_hit) : (cnt == CNT_W'(STRB_CYC - 1));

  assign req_ready  = (st == S_IDLE);
  assign bus_ad_out = in_addr ? (cnt[1] ? a_ext[7:0] : a_ext[15:8])
                    : (in_strb && wr_q) ? wd_q : 8'h00;
  assign bus_ad_oe  = in_addr | (in_strb & wr_q);
  assign bus_dir    = ~(in_strb & ~wr_q);
  assign bus_latch  = in_addr & cnt[0];
  assign bus_cs_n   = ~in_strb;
  assign bus_rd_n   = ~(in_strb & ~wr_q);
  assign bus_wr_n   = ~(in_strb & wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      mode_q    <= 1'b0;
      addr_q    <= '0;
      wd_q      <= '0;
      lim_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_ADDR;
          cnt    <= '0;
          wr_q   <= req_write;
          mode_q <= ack_mode;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          lim_q  <= timeout_lim;
        end
        S_ADDR: begin
          if (cnt == CNT_W'(3)) begin
            st  <= S_STRB;
            cnt <= '0;
          end else cnt <= cnt + CNT_W'(1);
        end
        S_STRB: begin
          if (strb_done) begin
            st        <= S_TURN;
            cnt       <= '0;
            rsp_valid <= 1'b1;
            rsp_rdata <= wr_q ? 8'h00 : bus_ad_in;
            rsp_err   <= mode_q & ~ack_seen;
          end else cnt <= cnt + CNT_W'(1);
        end
        default: begin
          if (cnt == CNT_W'(TURN_CYC - 1)) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + CNT_W'(1);
        end
      endcase
    end
  end

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (!bus_cs_n && (bus_rd_n || bus_wr_n)));
  a_r5_read_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (!bus_ad_oe && !bus_dir));
  a_r3_latch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_latch |=> !bus_latch);
  a_r3_latch_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_latch |-> (bus_ad_oe && bus_cs_n));
  a_r6_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r6_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r9_busy_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && bus_cs_n));
  a_r2_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/tb_mux_bus_master.sv
module tb_mux_bus_master;
  localparam int CLK_PERIOD = 20;
  localparam int STRB = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ack_mode = 0, bus_ack_n = 1;
  logic [10:0] req_addr = '0;
  logic [7:0] req_wdata = '0, timeout_lim = '0, bus_ad_in = '0;
  logic req_ready, rsp_valid, rsp_err, bus_ad_oe, bus_dir, bus_latch, bus_cs_n, bus_rd_n, bus_wr_n;
  logic [7:0] rsp_rdata, bus_ad_out;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ack_mode(ack_mode), .timeout_lim(timeout_lim), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_dir(bus_dir),
    .bus_latch(bus_latch), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ack_n(bus_ack_n));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int strobe_len(input logic am, input int ad, input logic [7:0] lim);
    int eff = (lim == 0) ? 1 : int'(lim);
    if (!am) return STRB;
    if (ad >= 0 && ad < eff) return ad + 1;
    return eff;
  endfunction

  function automatic logic exp_err(input logic am, input int ad, input logic [7:0] lim);
    int eff = (lim == 0) ? 1 : int'(lim);
    return am && !(ad >= 0 && ad < eff);
  endfunction

  task automatic txn(input logic w, input logic [10:0] a, input logic [7:0] wd,
                     input logic am, input int ad, input logic [7:0] lim,
                     input logic [7:0] rv, input logic spam);
    int n = strobe_len(am, ad, lim);
    logic e = exp_err(am, ad, lim);
    chk(32'(req_ready), 1, "R2 ready while idle");
    req_valid = 1; req_write = w; req_addr = a; req_wdata = wd;
    ack_mode = am; timeout_lim = lim;
    @(negedge clk);
    if (spam) begin
      req_addr = ~a; req_wdata = ~wd; req_write = ~w; ack_mode = ~am; timeout_lim = 8'd200;
    end else req_valid = 0;
    for (int i = 1; i <= 8 + n; i++) begin
      if (i <= 4) begin
        chk(32'(bus_ad_out), (i <= 2) ? 32'({5'b0, a[10:8]}) : 32'(a[7:0]), "R3 address byte");
        chk(32'(bus_latch), (i == 2 || i == 4) ? 1 : 0, "R3 latch pulse");
        chk(32'({bus_ad_oe, bus_dir, bus_cs_n, bus_rd_n, bus_wr_n}), 32'h1F, "R3 address controls");
        chk(32'(req_ready), 0, "R2 busy during address");
      end else if (i <= 4 + n) begin
        chk(32'({bus_cs_n, bus_rd_n, bus_wr_n}), w ? 32'b010 : 32'b001, "R4 strobe levels");
        if (w) chk(32'({bus_ad_oe, bus_dir, bus_ad_out}), 32'({2'b11, wd}), "R4 write drive");
        else   chk(32'({bus_ad_oe, bus_dir}), 0, "R5 read tristate");
        chk(32'(rsp_valid), 0, "R6 no early response");
        bus_ad_in = (i == 4 + n) ? rv : ~rv;
        bus_ack_n = !(ad >= 0 && (i - 5) >= ad);
      end else if (i == 5 + n) begin
        bus_ack_n = 1;
        chk(32'(rsp_valid), 1, am ? "R7 response after ack/timeout" : "R6 response after fixed access");
        chk(32'(rsp_rdata), w ? 0 : 32'(rv), "R5 read byte");
        chk(32'(rsp_err), 32'(e), am ? "R8 timeout flag" : "R6 no error fixed mode");
        chk(32'({bus_cs_n, bus_rd_n, bus_wr_n, bus_latch, bus_ad_oe, req_ready}), 32'b111000, "R9 turnaround start");
      end else if (i <= 7 + n) begin
        chk(32'(rsp_valid), 0, "R6 single pulse");
        chk(32'({bus_cs_n, bus_rd_n, bus_wr_n, bus_latch, bus_ad_oe, req_ready}), 32'b111000, "R9 turnaround");
        if (i == 7 + n) req_valid = 0;
      end else begin
        chk(32'(req_ready), 1, "R9 ready after turnaround");
        chk(32'(bus_cs_n), 1, "R2 no accept while busy");
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 2 + 3);
    chk(32'({req_ready, bus_cs_n, bus_rd_n, bus_wr_n, bus_latch, bus_ad_oe, rsp_valid}), 32'b1111000, "R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(32'({req_ready, bus_cs_n, bus_rd_n, bus_wr_n, bus_latch, bus_ad_oe, rsp_valid}), 32'b1111000, "R1 after reset");
    txn(1, 11'h7FF, 8'hA5, 0, -1, 8'd0, 8'h00, 0);
    txn(0, 11'h123, 8'h00, 0,  0, 8'd0, 8'h3C, 0);
    txn(0, 11'h0F0, 8'h00, 1,  0, 8'd5, 8'h81, 0);
    txn(1, 11'h505, 8'h5A, 1,  2, 8'd5, 8'h00, 0);
    txn(0, 11'h2AA, 8'h00, 1, -1, 8'd4, 8'h77, 0);
    txn(0, 11'h155, 8'h00, 1, -1, 8'd0, 8'h11, 0);
    txn(0, 11'h001, 8'h00, 1,  3, 8'd4, 8'hE7, 0);
    txn(1, 11'h400, 8'hC3, 1,  4, 8'd4, 8'h00, 0);
    txn(0, 11'h3FE, 8'h00, 0, -1, 8'd1, 8'h96, 1);
    for (int k = 0; k < 40; k++) begin
      int ad = int'($urandom_range(0, 13)) - 1;
      txn(1'($urandom_range(0, 1)), 11'($urandom), 8'($urandom), 1'($urandom_range(0, 1)),
          ad, 8'($urandom_range(0, 12)), 8'($urandom), 1'($urandom_range(0, 1)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule